// File: doc/BRIEF.md
# Vector Widening Pairwise Add/Subtract Unit

This block is one stage of a 128-bit vector datapath. It reads two 128-bit operands and writes one 128-bit result. The result has half as many lanes as the sources, and each result lane is twice as wide as a source lane. To build result lane i, the block takes lane 2i (even mode) or lane 2i+1 (odd mode) from each operand. It widens both picked lanes to the result lane width, by zero-extension or by sign-extension. It then adds them, or subtracts the second from the first. The result wraps modulo the wide lane width, and no flags are produced.

A mode word selects the source lane width (8, 16, 32 or 64 bits), the lane parity, the extension kind and the operation. Operands are taken on a clock edge when `in_valid` is high. The result and `out_valid` are valid after that edge. A small two-state controller (IDLE, HOLD) drives the output valid flag. It moves IDLE→HOLD on an accepted input (transition ACCEPT), HOLD→HOLD on a back-to-back input (transition REFILL), HOLD→IDLE when no input arrives (transition DRAIN), and stays in IDLE with no input (transition WAIT). Reset forces IDLE.

Top module: `vwiden_addsub`

## Requirements
- R1: A synchronous reset (`rst` high) clears `out_valid` to 0, and `out_valid` stays 0 until an input is accepted.
- R2: When `in_valid` is high at a rising edge, `out_valid` is 1 after that edge and `res` holds the result for that edge's operands and mode. When `in_valid` is low at an edge, `out_valid` is 0 after that edge.
- R3: The size field is `mode[1:0]`: 0 means 8→16, 1 means 16→32, 2 means 32→64, and 3 means 64→128. Result lane i occupies `res` bits [2W(i+1)-1 : 2W·i], where W is the source lane width.
- R4: With `mode[2]` = 0 (even), result lane i uses source lane 2i of `opa` and `opb`. Source lane k occupies bits [W(k+1)-1 : W·k].
- R5: With `mode[2]` = 1 (odd), result lane i uses source lane 2i+1.
- R6: With `mode[3]` = 1, each picked source lane is sign-extended before the operation. With `mode[3]` = 0, it is zero-extended.
- R7: With `mode[4]` = 0, the lane result is ext(a)+ext(b). With `mode[4]` = 1, it is ext(a)−ext(b). Both wrap modulo 2^(2W).
- R8: Source lanes that are not picked have no effect on `res`.
- R9: While `in_valid` is low, `res` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 5 | [1:0] size, [2] odd, [3] signed, [4] subtract |
| opa | input | 128 | First source vector |
| opb | input | 128 | Second source vector |
| out_valid | output | 1 | `res` holds a new result |
| res | output | 128 | Widened result vector |

## Verification
The case hardest to reach from the ports is the 64→128 signed subtract. It needs a borrow that runs through the full 128-bit lane, and random data seldom gives the extreme values that show it. Directed vectors put 0x8000_0000_0000_0000 against 0x7FFF_FFFF_FFFF_FFFF in both parities and both extension kinds. Random vectors then cover every mode. The non-picked lanes are filled with random data to show that they do not leak into the result.

// File: rtl/vwiden_pkg.sv
package vwiden_pkg;
    localparam int VEC_W = 128;
    localparam int MODE_W = 5;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } size_e;

    typedef struct packed {
        logic  sub;
        logic  sgn;
        logic  odd;
        size_e size;
    } mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } vstate_e;
endpackage

// File: rtl/vwiden_lanes.sv
module vwiden_lanes #(
    parameter int VW = 128,
    parameter int SW = 8
) (
    input  logic          odd,
    input  logic          sgn,
    input  logic          sub,
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    localparam int WW = 2 * SW;
    localparam int NL = VW / WW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [SW-1:0] ea, oa, eb, ob, pa, pb;
        logic [WW-1:0] xa, xb;
        assign ea = a[WW*i      +: SW];
        assign oa = a[WW*i + SW +: SW];
        assign eb = b[WW*i      +: SW];
        assign ob = b[WW*i + SW +: SW];
        assign pa = odd ? oa : ea;
        assign pb = odd ? ob : eb;
        assign xa = {{SW{sgn & pa[SW-1]}}, pa};
        assign xb = {{SW{sgn & pb[SW-1]}}, pb};
        assign y[WW*i +: WW] = sub ? (xa - xb) : (xa + xb);
    end
endmodule

// File: rtl/vwiden_ctrl.sv
module vwiden_ctrl
    import vwiden_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic load,
    output logic out_valid
);
    vstate_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_nx = in_valid ? ST_HOLD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        load      = in_valid;
        out_valid = (state == ST_HOLD);
    end
endmodule

// File: rtl/vwiden_addsub.sv
module vwiden_addsub
    import vwiden_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [MODE_W-1:0] mode,
    input  logic [VEC_W-1:0]  opa,
    input  logic [VEC_W-1:0]  opb,
    output logic              out_valid,
    output logic [VEC_W-1:0]  res
);
    localparam int NSZ = 4;

    mode_t m;
    assign m = mode_t'(mode);

    logic [VEC_W-1:0] cand [NSZ];

    for (genvar s = 0; s < NSZ; s++) begin : g_sz
        vwiden_lanes #(.VW(VEC_W), .SW(8 << s)) u_lanes (
            .odd (m.odd),
            .sgn (m.sgn),
            .sub (m.sub),
            .a   (opa),
            .b   (opb),
            .y   (cand[s])
        );
    end

    logic load;
    vwiden_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .load      (load),
        .out_valid (out_valid)
    );

    logic [VEC_W-1:0] pick;
    always_comb begin
        unique case (m.size)
            SZ_B: pick = cand[0];
            SZ_H: pick = cand[1];
            SZ_W: pick = cand[2];
            SZ_D: pick = cand[3];
            default: pick = cand[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (load) res <= pick;
    end
endmodule

// File: rtl/vwiden_addsub_chk.sv
module vwiden_addsub_chk
    import vwiden_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [MODE_W-1:0] mode,
    input logic [VEC_W-1:0]  opa,
    input logic [VEC_W-1:0]  opb,
    input logic              out_valid,
    input logic [VEC_W-1:0]  res
);
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_res_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_valid) |=> $stable(res));
    // R7: an unsigned doubleword add of zero operands gives zero
    a_r7_zero_add: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 5'd3 && opa == '0 && opb == '0) |=> res == '0);
endmodule

bind vwiden_addsub vwiden_addsub_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .opa(opa), .opb(opb), .out_valid(out_valid), .res(res)
);

// File: tb/tb_vwiden_addsub.sv
module tb_vwiden_addsub;
    logic         clk = 0;
    logic         rst;
    logic         in_valid;
    logic [4:0]   mode;
    logic [127:0] opa, opb;
    logic         out_valid;
    logic [127:0] res;
    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    vwiden_addsub dut (.*);

    function automatic logic [127:0] model(input logic [4:0] md,
                                           input logic [127:0] a,
                                           input logic [127:0] b);
        logic [127:0] r = '0;
        int sw = 8 << md[1:0];
        int nl = 128 / (2 * sw);
        for (int i = 0; i < nl; i++) begin
            logic [127:0] xa = '0, xb = '0, s;
            int k = 2 * i + (md[2] ? 1 : 0);
            for (int j = 0; j < 2 * sw; j++) begin
                xa[j] = (j < sw) ? a[k*sw + j] : (md[3] & a[k*sw + sw - 1]);
                xb[j] = (j < sw) ? b[k*sw + j] : (md[3] & b[k*sw + sw - 1]);
            end
            s = md[4] ? xa - xb : xa + xb;
            for (int j = 0; j < 2 * sw; j++) r[2*sw*i + j] = s[j];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [4:0] md,
                       input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1; mode = md; opa = a; opb = b;
        @(negedge clk);
        in_valid = 0;
        chk({tag, " R2 valid"}, {127'd0, out_valid}, 128'd1);
        chk(tag, res, model(md, a, b));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] hold, mn, mx;
        void'($urandom(32'd1234));
        rst = 1; in_valid = 0; mode = 0; opa = 0; opb = 0;
        repeat (2) @(negedge clk);
        chk("R1 reset valid", {127'd0, out_valid}, 128'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 idle valid", {127'd0, out_valid}, 128'd0);

        // R3 R4: byte even add, lane 0 = 0x01+0x02
        run("R3 R4 byte even", 5'b00000, 128'h01, 128'h02);
        // R5: odd picks byte 1
        run("R5 byte odd", 5'b00100, 128'hFF00, 128'h0100);
        // R6: signed byte 0xFF + 0x01 = 0 in 16 bits
        run("R6 signed byte", 5'b01000, 128'hFF, 128'h01);
        chk("R6 value", res, 128'h0);
        // R6 unsigned: 0x00FF + 0x0001 = 0x0100
        run("R6 unsigned byte", 5'b00000, 128'hFF, 128'h01);
        chk("R6 uvalue", res, 128'h100);
        // R7: quad signed subtract at the extremes
        mn = {64'h0, 64'h8000_0000_0000_0000};
        mx = {64'h0, 64'h7FFF_FFFF_FFFF_FFFF};
        run("R7 quad signed sub", 5'b11011, mn, mx);
        chk("R7 qvalue", res, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001);
        run("R7 quad odd unsigned sub", 5'b10111, {mn[63:0], 64'h0}, {mx[63:0], 64'h0});
        run("R7 word sub", 5'b11010, rnd128(), rnd128());
        run("R3 half", 5'b01001, rnd128(), rnd128());

        // R8: odd lanes random, even lanes zero -> even result 0
        run("R8 ignore odd", 5'b00001, 128'hFFFF0000_FFFF0000_FFFF0000_FFFF0000,
            128'hABCD0000_1234_0000_5678_0000_9ABC_0000);
        chk("R8 zero", res, 128'h0);

        // R9 and R2 drop
        hold = res;
        @(negedge clk);
        opa = rnd128(); opb = rnd128(); mode = 5'b10000;
        @(negedge clk);
        chk("R2 valid drop", {127'd0, out_valid}, 128'd0);
        chk("R9 hold", res, hold);

        for (int n = 0; n < 200; n++) begin
            logic [4:0] md = 5'($urandom);
            run("R3 R4 R5 R6 R7 random", md, rnd128(), rnd128());
        end

        // R1: reset mid-stream
        @(negedge clk);
        in_valid = 1; rst = 1;
        @(negedge clk);
        in_valid = 0; rst = 0;
        chk("R1 reset again", {127'd0, out_valid}, 128'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++; tests++;
        $display("FAIL watchdog");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule